// File: doc/BRIEF.md
# UART Sleep/Wake Controller

This block decides when a two-channel UART may switch off its crystal oscillator, and when it has to switch it back on. It runs on a free-running low-rate clock that keeps going while the main oscillator is stopped. The inputs for each channel are:

- the interrupt-idle status bit;
- the baud divisor;
- the per-channel sleep-enable bit;
- the modem-status delta flags;
- the asynchronous receive line;
- a strobe marking a byte written toward the transmitter;
- the four asynchronous modem input pins.

The block drives an oscillator-enable output, a sleep flag, and a clock-ready flag. The clock-ready flag stays low while the restarted oscillator is settling.

Sleep is entered only when every condition holds on both channels for two consecutive clocks. The block wakes on any of these events:

- a start-bit edge on either receive line;
- a transmit load;
- a level change on any modem pin;
- software clearing a sleep-enable bit.

After a wake, the block waits a parameterized settle time. It then goes back to sleep by itself once software has serviced the interrupts and cleared the delta flags.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset the oscillator enable is 1 and the sleep flag is 0. Reset release passes through a two-stage synchronizer, and the block then counts SETTLE_CYC cycles. As a result, clock_ready rises 2+SETTLE_CYC clocks after rst_n rises.
- R2: Sleep is entered when every entry condition holds on both channels for QUAL_CYC consecutive clocks. The sleep flag rises on the QUAL_CYC-th rising edge after the inputs settle.
- R3: Sleep is never entered while any of the following holds on either channel: interrupt pending (irq_none bit = 0), divisor equal to zero, sleep_en bit = 0, any msr_delta bit set, or the synchronized rx line at 0. A divisor whose only nonzero bits are in the upper byte counts as nonzero.
- R4: osc_en is exactly the inverse of the sleep flag, and clk_ready is 0 while asleep.
- R5: A 1-to-0 transition on either rx_pin wakes the block. The sleep flag falls on the third rising edge after the pin changes.
- R6: A tx_load strobe on either channel while asleep clears the sleep flag at the next rising edge.
- R7: A change of level, in either direction, on any modem pin wakes the block on the third rising edge. Channel c owns modem_pin[4c+3:4c].
- R8: Sleep continues as long as both sleep_en bits stay set. Clearing either bit wakes the block at the next edge and keeps it awake.
- R9: After a wake, clk_ready stays 0 for SETTLE_CYC clocks, and no entry evaluation takes place during that window.
- R10: After a wake the block returns to sleep by itself once the conditions hold again. A pending interrupt or a set delta flag keeps it awake until that flag is cleared.
- R11: Entry conditions that hold for fewer than QUAL_CYC consecutive clocks do not cause sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_none | input | NCH | Per channel, 1 = no interrupt pending |
| divisor | input | NCH*DIV_W | Baud divisor per channel, channel c at [DIV_W*c +: DIV_W] |
| sleep_en | input | NCH | Per-channel sleep enable |
| msr_delta | input | NCH*MDM_W | Modem-status change flags per channel |
| rx_pin | input | NCH | Asynchronous receive lines |
| tx_load | input | NCH | Transmit byte load strobe, synchronous to clk |
| modem_pin | input | NCH*MDM_W | Asynchronous modem input pins |
| osc_en | output | 1 | Oscillator enable |
| asleep | output | 1 | Sleep state flag |
| clk_ready | output | 1 | Oscillator settled, normal operation |

## Verification
The bench builds the block with SETTLE_CYC = 6 and QUAL_CYC = 2. With these values every cycle of the settle window can be counted out, both after reset and after each wake. The wake-to-resleep path is also short enough to check clock by clock. The three-edge synchronizer latency and the two-cycle qualification are exercised at their exact edges. Each entry condition is violated on its own on one channel while all the others hold.

// File: rtl/uslp_pkg.sv
package uslp_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } uslp_state_e;
endpackage

// File: rtl/uslp_sync.sv
// Two-flop synchronizer with a selectable reset level.
module uslp_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {W{RST_VAL}};
      s2_q <= {W{RST_VAL}};
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/uslp_wake_det.sv
// Synchronizes the asynchronous wake sources and flags wake events.
module uslp_wake_det #(
  parameter int NCH   = 2,
  parameter int MDM_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       rx_pin,
  input  logic [NCH*MDM_W-1:0] modem_pin,
  input  logic [NCH-1:0]       tx_load,
  output logic [NCH-1:0]       rx_lvl,
  output logic                 wake_any
);
  localparam int MW = NCH * MDM_W;

  logic [NCH-1:0] rx_s, rx_prev_q, rx_prev_d, rx_fall;
  logic [MW-1:0]  mdm_s, mdm_prev_q, mdm_prev_d, mdm_chg;

  uslp_sync #(.W(NCH), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s)
  );

  uslp_sync #(.W(MW), .RST_VAL(1'b0)) u_mdm_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_pin), .q(mdm_s)
  );

  always_comb begin
    rx_prev_d  = rx_s;
    mdm_prev_d = mdm_s;
    rx_fall    = rx_prev_q & ~rx_s;
    mdm_chg    = mdm_prev_q ^ mdm_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev_q  <= '1;
      mdm_prev_q <= '0;
    end else begin
      rx_prev_q  <= rx_prev_d;
      mdm_prev_q <= mdm_prev_d;
    end
  end

  assign rx_lvl   = rx_s;
  assign wake_any = (|rx_fall) | (|mdm_chg) | (|tx_load);
endmodule

// File: rtl/uslp_entry_chk.sv
// Per-channel entry condition check, combined across channels.
module uslp_entry_chk #(
  parameter int NCH   = 2,
  parameter int DIV_W = 16,
  parameter int MDM_W = 4
) (
  input  logic [NCH-1:0]       irq_none,
  input  logic [NCH*DIV_W-1:0] divisor,
  input  logic [NCH-1:0]       sleep_en,
  input  logic [NCH*MDM_W-1:0] msr_delta,
  input  logic [NCH-1:0]       rx_lvl,
  output logic                 all_ok
);
  logic [NCH-1:0] ch_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_ok[c] = irq_none[c]
                    & (|divisor[DIV_W*c +: DIV_W])
                    & sleep_en[c]
                    & ~(|msr_delta[MDM_W*c +: MDM_W])
                    & rx_lvl[c];
  end

  assign all_ok = &ch_ok;
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uslp_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int DIV_W      = 16,
  parameter int MDM_W      = 4,
  parameter int SETTLE_CYC = 64,
  parameter int QUAL_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       irq_none,
  input  logic [NCH*DIV_W-1:0] divisor,
  input  logic [NCH-1:0]       sleep_en,
  input  logic [NCH*MDM_W-1:0] msr_delta,
  input  logic [NCH-1:0]       rx_pin,
  input  logic [NCH-1:0]       tx_load,
  input  logic [NCH*MDM_W-1:0] modem_pin,
  output logic                 osc_en,
  output logic                 asleep,
  output logic                 clk_ready
);
  localparam int CNT_W  = $clog2(SETTLE_CYC + 1);
  localparam int QUAL_W = $clog2(QUAL_CYC + 1);

  // reset: asserted asynchronously, released on clk
  logic rst_s1_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ns   <= rst_s1_q;
    end
  end

  logic [NCH-1:0] rx_lvl;
  logic           wake_any, all_ok;

  uslp_wake_det #(.NCH(NCH), .MDM_W(MDM_W)) u_wake (
    .clk(clk), .rst_n(rst_ns), .rx_pin(rx_pin), .modem_pin(modem_pin),
    .tx_load(tx_load), .rx_lvl(rx_lvl), .wake_any(wake_any)
  );

  uslp_entry_chk #(.NCH(NCH), .DIV_W(DIV_W), .MDM_W(MDM_W)) u_entry (
    .irq_none(irq_none), .divisor(divisor), .sleep_en(sleep_en),
    .msr_delta(msr_delta), .rx_lvl(rx_lvl), .all_ok(all_ok)
  );

  uslp_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [QUAL_W-1:0] qual_q, qual_d;
  logic              cnt_en, qual_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    qual_d  = qual_q;
    unique case (state_q)
      ST_RUN: begin
        if (all_ok && !wake_any) begin
          if (qual_q == QUAL_W'(QUAL_CYC - 1)) begin
            state_d = ST_SLEEP;
            qual_d  = '0;
          end else begin
            qual_d = qual_q + QUAL_W'(1);
          end
        end else begin
          qual_d = '0;
        end
      end
      ST_SLEEP: begin
        if (wake_any || !(&sleep_en)) begin
          state_d = ST_SETTLE;
          cnt_d   = CNT_W'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          state_d = ST_RUN;
          qual_d  = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_SETTLE;
        cnt_d   = CNT_W'(SETTLE_CYC - 1);
      end
    endcase
  end

  assign cnt_en  = (cnt_d != cnt_q);
  assign qual_en = (qual_d != qual_q);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_SETTLE;
      cnt_q   <= CNT_W'(SETTLE_CYC - 1);
      qual_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (qual_en) qual_q <= qual_d;
    end
  end

  assign osc_en    = (state_q != ST_SLEEP);
  assign asleep    = (state_q == ST_SLEEP);
  assign clk_ready = (state_q == ST_RUN);

  // entry only after two consecutive qualifying clocks
  assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(asleep) |-> ($past(all_ok, 1) && $past(all_ok, 2)));

  // no entry with an interrupt pending on any channel
  assert_no_sleep_irq_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(asleep) |-> $past(&irq_none));

  // a detected wake event always ends sleep
  assert_wake_exits_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (asleep && wake_any) |=> !asleep);

  // clearing a sleep enable ends sleep
  assert_enable_clear_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (asleep && !(&sleep_en)) |=> !asleep);

  // no ready indication straight out of sleep
  assert_wake_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(asleep) |-> !clk_ready);

  // settle window is not cut short
  assert_settle_holds_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_SETTLE && cnt_q != '0) |=> (state_q == ST_SETTLE));

  // oscillator gated only in sleep
  assert_osc_follows_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(osc_en) |-> asleep);
endmodule

// File: tb/uart_sleep_ctrl_bench.sv
module uart_sleep_ctrl_bench;
  localparam int NCH = 2, DIV_W = 16, MDM_W = 4, SETTLE = 6, QUAL = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n;
  logic [NCH-1:0]       irq_none, sleep_en, rx_pin, tx_load;
  logic [NCH*DIV_W-1:0] divisor;
  logic [NCH*MDM_W-1:0] msr_delta, modem_pin;
  logic                 osc_en, asleep, clk_ready;

  uart_sleep_ctrl #(.NCH(NCH), .DIV_W(DIV_W), .MDM_W(MDM_W),
                    .SETTLE_CYC(SETTLE), .QUAL_CYC(QUAL)) u_uart_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_none(irq_none), .divisor(divisor),
    .sleep_en(sleep_en), .msr_delta(msr_delta), .rx_pin(rx_pin),
    .tx_load(tx_load), .modem_pin(modem_pin), .osc_en(osc_en),
    .asleep(asleep), .clk_ready(clk_ready)
  );

  int    total = 0, bad = 0;
  bit    finished = 0;
  string q_tag[$];
  logic [1:0] q_exp[$];

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s {asleep,clk_ready,osc_en} got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // driver: queue the expected state after the next rising edge
  task automatic chk(string tag, logic s, logic r);
    q_tag.push_back(tag);
    q_exp.push_back({s, r});
    @(negedge clk);
  endtask

  // monitor: compare right after each edge
  always @(posedge clk) begin : mon
    string t;
    logic [1:0] e;
    #1;
    if (q_exp.size() != 0) begin
      t = q_tag.pop_front();
      e = q_exp.pop_front();
      check(t, {asleep, clk_ready, osc_en}, {e[1], e[0], ~e[1]});
    end
  end

  task automatic apply_good();
    irq_none  = '1;
    divisor   = {16'h0100, 16'h0001};
    sleep_en  = '1;
    msr_delta = '0;
    rx_pin    = '1;
    tx_load   = '0;
  endtask

  task automatic violate(int k);
    case (k)
      0: irq_none[0]     = 1'b0;
      1: irq_none[1]     = 1'b0;
      2: divisor[15:0]   = 16'h0000;
      3: divisor[31:16]  = 16'h0000;
      4: sleep_en[1]     = 1'b0;
      5: msr_delta[3]    = 1'b1;
      default: msr_delta[4] = 1'b1;
    endcase
  endtask

  task automatic settle();
    for (int i = 0; i < SETTLE - 1; i++) chk("R9", 1'b0, 1'b0);
    chk("R9", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    apply_good();
    sleep_en  = '0;
    modem_pin = '0;
    repeat (3) @(negedge clk);
    check("R1", {asleep, clk_ready, osc_en}, 3'b001);
    rst_n = 1'b1;
    for (int i = 0; i < SETTLE + 1; i++) chk("R1", 1'b0, 1'b0);
    chk("R1", 1'b0, 1'b1);

    // R3: rx low on channel 1 while everything else holds
    rx_pin[1] = 1'b0;
    repeat (3) chk("R3", 1'b0, 1'b1);
    sleep_en = '1;
    repeat (4) chk("R3", 1'b0, 1'b1);
    // R3: each remaining condition violated alone
    for (int k = 0; k < 7; k++) begin
      apply_good();
      violate(k);
      repeat (4) chk("R3", 1'b0, 1'b1);
    end

    // R11: one good cycle only
    apply_good();
    chk("R11", 1'b0, 1'b1);
    irq_none[0] = 1'b0;
    repeat (3) chk("R11", 1'b0, 1'b1);

    // R2: entry on the second qualifying edge; R4 while asleep
    apply_good();
    chk("R2", 1'b0, 1'b1);
    chk("R2", 1'b1, 1'b0);
    repeat (3) chk("R4", 1'b1, 1'b0);

    // R6: transmit load wakes at once, then R10 re-sleep
    tx_load[0] = 1'b1;
    chk("R6", 1'b0, 1'b0);
    tx_load = '0;
    settle();
    chk("R10", 1'b0, 1'b1);
    chk("R10", 1'b1, 1'b0);

    // R5: start bit on channel 0; interrupt holds it awake (R10)
    rx_pin[0] = 1'b0;
    chk("R5", 1'b1, 1'b0);
    chk("R5", 1'b1, 1'b0);
    chk("R5", 1'b0, 1'b0);
    irq_none[0] = 1'b0;
    chk("R9", 1'b0, 1'b0);
    rx_pin[0] = 1'b1;
    repeat (SETTLE - 2) chk("R9", 1'b0, 1'b0);
    chk("R9", 1'b0, 1'b1);
    repeat (3) chk("R10", 1'b0, 1'b1);
    irq_none[0] = 1'b1;
    chk("R10", 1'b0, 1'b1);
    chk("R10", 1'b1, 1'b0);

    // R7: modem pin rises on channel 1; delta flag holds it awake
    modem_pin[6] = 1'b1;
    chk("R7", 1'b1, 1'b0);
    chk("R7", 1'b1, 1'b0);
    chk("R7", 1'b0, 1'b0);
    msr_delta[6] = 1'b1;
    settle();
    repeat (3) chk("R10", 1'b0, 1'b1);
    msr_delta = '0;
    chk("R10", 1'b0, 1'b1);
    chk("R10", 1'b1, 1'b0);

    // R7: same pin falls
    modem_pin[6] = 1'b0;
    chk("R7", 1'b1, 1'b0);
    chk("R7", 1'b1, 1'b0);
    chk("R7", 1'b0, 1'b0);
    settle();
    chk("R10", 1'b0, 1'b1);
    chk("R10", 1'b1, 1'b0);

    // R8: stays asleep while enabled, leaves when a bit is cleared
    repeat (3) chk("R8", 1'b1, 1'b0);
    sleep_en[1] = 1'b0;
    chk("R8", 1'b0, 1'b0);
    settle();
    repeat (3) chk("R8", 1'b0, 1'b1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule